// File: doc/BRIEF.md
# Dual-Clock True Dual-Port RAM with Selectable Read-During-Write Output

This block is a synchronous memory with two ports, A and B. Each port has its own clock, enable, synchronous output reset, lane write enables, address, write data and registered read data. The ports do not depend on each other. They share only the storage words, so a word written through one port can be read through the other. Words are split into 9-bit lanes, and each lane can be written on its own. Per-lane partial writes on either side are a normal way to use the block.

Each port has a build-time choice that sets what its read output shows in a cycle where that port writes. The choices are the old stored word, the word as it stands after the write, or the last output left unchanged. Each port can also add an output register. That register adds one cycle of read latency. A synchronous reset input on each port loads a parameterised initial value into that port's output stages. Every storage word starts at a parameterised fill value.

Top module: `tdpram`

## Requirements
- R1: When a port's reset input is high at a clock edge, that port's output shows its configured initial value after the edge. This holds whether or not the port's enable is high. The output holds that value for as long as reset is high and the port stays idle.
- R2: A read on a port whose output register is off shows the addressed word on the output after the same edge at which the address is presented.
- R3: Write-enable bit k changes only bits [9k+8:9k] of the addressed word. Lanes whose enable bit is low keep their previous contents.
- R4: A port set to show old data presents, during a write, the whole word as it was before that write.
- R5: A port set to show new data presents, during a write, the word after the write. Enabled lanes show the new data and the other lanes show the kept contents.
- R6: A port set to keep its output leaves its read stage unchanged during a write, but the write still takes effect.
- R7: While a port's enable is low and its reset is low, the port does not write and its output does not change.
- R8: A lane written through one port is read back through the other port. When the two ports write the same lane at different times, the later write decides the stored value.
- R9: With the output register on, read data appears one edge later than without it, and that port's reset loads the initial value into the output register.
- R10: Before any write, every word reads as the fill value, including the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable for read, write and output update |
| rst_a | input | 1 | Port A synchronous output reset to the initial value |
| we_a | input | LANES | Port A per-lane write enables, bit k for bits [9k+8:9k] |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | LANES*9 | Port A write data |
| dout_a | output | LANES*9 | Port A read data |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable for read, write and output update |
| rst_b | input | 1 | Port B synchronous output reset to the initial value |
| we_b | input | LANES | Port B per-lane write enables, bit k for bits [9k+8:9k] |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | LANES*9 | Port B write data |
| dout_b | output | LANES*9 | Port B read data |

## Verification
The port checkers assume three things. The two ports never write the same lane of the same word in one cycle. Inputs are stable around each port's rising edge. A port's reset is high at some edge before its output is relied on. The bench drives everything on the falling edge of a clock shared by both ports. It keeps simultaneous accesses from the two ports on separate cycles, so no cross-port collision is ever created. It also starts every run with reset high on each port. The checkers ignore each port's first edge, because the outputs still hold power-up values at that point.

// File: rtl/tdpram_pkg.sv
package tdpram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    RDW_OLD  = 2'd0,
    RDW_NEW  = 2'd1,
    RDW_KEEP = 2'd2
  } rdw_mode_e;
endpackage

// File: rtl/tdpram_store.sv
module tdpram_store #(
  parameter int ADDR_W = 9,
  parameter int LANES = 4,
  parameter logic [LANES*tdpram_pkg::LANE_W-1:0] FILL = '0
) (
  input  logic                       clk_a,
  input  logic [LANES-1:0]           lanes_a,
  input  logic [ADDR_W-1:0]          addr_a,
  input  logic [LANES*tdpram_pkg::LANE_W-1:0] din_a,
  output logic [LANES*tdpram_pkg::LANE_W-1:0] old_a,
  input  logic                       clk_b,
  input  logic [LANES-1:0]           lanes_b,
  input  logic [ADDR_W-1:0]          addr_b,
  input  logic [LANES*tdpram_pkg::LANE_W-1:0] din_b,
  output logic [LANES*tdpram_pkg::LANE_W-1:0] old_b
);
  localparam int LW = tdpram_pkg::LANE_W;
  localparam int W = LANES * LW;
  localparam int DEPTH = 1 << ADDR_W;

  // Each port owns one bank and one tag set; a lane is current in bank A
  // when the two tags agree, otherwise in bank B.
  logic [W-1:0]     bank_a [DEPTH];
  logic [W-1:0]     bank_b [DEPTH];
  logic [LANES-1:0] tag_a  [DEPTH];
  logic [LANES-1:0] tag_b  [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      bank_a[i] = FILL;
      bank_b[i] = FILL;
      tag_a[i]  = '0;
      tag_b[i]  = '0;
    end
  end

  function automatic logic [W-1:0] resolve(input logic [W-1:0] wa, input logic [W-1:0] wb,
                                           input logic [LANES-1:0] ta, input logic [LANES-1:0] tb);
    logic [W-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*LW +: LW] = (ta[l] == tb[l]) ? wa[l*LW +: LW] : wb[l*LW +: LW];
    return r;
  endfunction

  assign old_a = resolve(bank_a[addr_a], bank_b[addr_a], tag_a[addr_a], tag_b[addr_a]);
  assign old_b = resolve(bank_a[addr_b], bank_b[addr_b], tag_a[addr_b], tag_b[addr_b]);

  always_ff @(posedge clk_a) begin
    for (int l = 0; l < LANES; l++) begin
      if (lanes_a[l]) begin
        bank_a[addr_a][l*LW +: LW] <= din_a[l*LW +: LW];
        tag_a[addr_a][l]           <= tag_b[addr_a][l];
      end
    end
  end

  always_ff @(posedge clk_b) begin
    for (int l = 0; l < LANES; l++) begin
      if (lanes_b[l]) begin
        bank_b[addr_b][l*LW +: LW] <= din_b[l*LW +: LW];
        tag_b[addr_b][l]           <= ~tag_a[addr_b][l];
      end
    end
  end
endmodule

// File: rtl/tdpram_port.sv
module tdpram_port #(
  parameter int LANES = 4,
  parameter tdpram_pkg::rdw_mode_e MODE = tdpram_pkg::RDW_OLD,
  parameter bit OUT_REG = 1'b0,
  parameter logic [LANES*tdpram_pkg::LANE_W-1:0] INIT = '0
) (
  input  logic                       clk,
  input  logic                       en,
  input  logic                       rst,
  input  logic [LANES-1:0]           we,
  input  logic [LANES*tdpram_pkg::LANE_W-1:0] din,
  input  logic [LANES*tdpram_pkg::LANE_W-1:0] old_word,
  output logic [LANES*tdpram_pkg::LANE_W-1:0] lat_q,
  output logic [LANES*tdpram_pkg::LANE_W-1:0] dout
);
  localparam int LW = tdpram_pkg::LANE_W;
  localparam int W = LANES * LW;

  function automatic logic [W-1:0] merge(input logic [W-1:0] prev, input logic [W-1:0] nw,
                                         input logic [LANES-1:0] sel);
    logic [W-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*LW +: LW] = sel[l] ? nw[l*LW +: LW] : prev[l*LW +: LW];
    return r;
  endfunction

  logic writing;
  assign writing = |we;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= INIT;
    end else if (en) begin
      if (!writing) begin
        lat_q <= old_word;
      end else begin
        case (MODE)
          tdpram_pkg::RDW_OLD: lat_q <= old_word;
          tdpram_pkg::RDW_NEW: lat_q <= merge(old_word, din, we);
          default:             lat_q <= lat_q;
        endcase
      end
    end
  end

  generate
    if (OUT_REG) begin : g_pipe
      logic [W-1:0] pipe_q;
      always_ff @(posedge clk) begin
        if (rst)     pipe_q <= INIT;
        else if (en) pipe_q <= lat_q;
      end
      assign dout = pipe_q;
    end else begin : g_direct
      assign dout = lat_q;
    end
  endgenerate
endmodule

// File: rtl/tdpram.sv
module tdpram #(
  parameter int ADDR_W = 9,
  parameter int LANES = 4,
  parameter tdpram_pkg::rdw_mode_e MODE_A = tdpram_pkg::RDW_OLD,
  parameter tdpram_pkg::rdw_mode_e MODE_B = tdpram_pkg::RDW_OLD,
  parameter bit OUT_REG_A = 1'b0,
  parameter bit OUT_REG_B = 1'b0,
  parameter logic [LANES*tdpram_pkg::LANE_W-1:0] INIT_A = '0,
  parameter logic [LANES*tdpram_pkg::LANE_W-1:0] INIT_B = '0,
  parameter logic [LANES*tdpram_pkg::LANE_W-1:0] MEM_FILL = '0
) (
  input  logic                       clk_a,
  input  logic                       en_a,
  input  logic                       rst_a,
  input  logic [LANES-1:0]           we_a,
  input  logic [ADDR_W-1:0]          addr_a,
  input  logic [LANES*tdpram_pkg::LANE_W-1:0] din_a,
  output logic [LANES*tdpram_pkg::LANE_W-1:0] dout_a,
  input  logic                       clk_b,
  input  logic                       en_b,
  input  logic                       rst_b,
  input  logic [LANES-1:0]           we_b,
  input  logic [ADDR_W-1:0]          addr_b,
  input  logic [LANES*tdpram_pkg::LANE_W-1:0] din_b,
  output logic [LANES*tdpram_pkg::LANE_W-1:0] dout_b
);
  localparam int W = LANES * tdpram_pkg::LANE_W;

  // Named internal events for the checkers.
  logic [LANES-1:0] lanes_a, lanes_b;
  logic [W-1:0]     old_a, old_b;
  logic [W-1:0]     lat_a, lat_b;

  assign lanes_a = en_a ? we_a : '0;
  assign lanes_b = en_b ? we_b : '0;

  tdpram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .FILL(MEM_FILL)) u_store (
    .clk_a(clk_a), .lanes_a(lanes_a), .addr_a(addr_a), .din_a(din_a), .old_a(old_a),
    .clk_b(clk_b), .lanes_b(lanes_b), .addr_b(addr_b), .din_b(din_b), .old_b(old_b)
  );

  tdpram_port #(.LANES(LANES), .MODE(MODE_A), .OUT_REG(OUT_REG_A), .INIT(INIT_A)) u_port_a (
    .clk(clk_a), .en(en_a), .rst(rst_a), .we(we_a), .din(din_a),
    .old_word(old_a), .lat_q(lat_a), .dout(dout_a)
  );

  tdpram_port #(.LANES(LANES), .MODE(MODE_B), .OUT_REG(OUT_REG_B), .INIT(INIT_B)) u_port_b (
    .clk(clk_b), .en(en_b), .rst(rst_b), .we(we_b), .din(din_b),
    .old_word(old_b), .lat_q(lat_b), .dout(dout_b)
  );
endmodule

// File: rtl/tdpram_chk.sv
module tdpram_chk #(
  parameter int LANES = 4,
  parameter tdpram_pkg::rdw_mode_e MODE = tdpram_pkg::RDW_OLD,
  parameter bit OUT_REG = 1'b0,
  parameter logic [LANES*tdpram_pkg::LANE_W-1:0] INIT = '0
) (
  input logic                       clk,
  input logic                       en,
  input logic                       rst,
  input logic [LANES-1:0]           we,
  input logic [LANES*tdpram_pkg::LANE_W-1:0] din,
  input logic [LANES*tdpram_pkg::LANE_W-1:0] old_word,
  input logic [LANES*tdpram_pkg::LANE_W-1:0] lat,
  input logic [LANES*tdpram_pkg::LANE_W-1:0] dout
);
  // Skip the first edge: outputs hold power-up values until then.
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  // R1: reset is the subject here, so only the power-up window is excluded
  assert_rst_init_R1: assert property (@(posedge clk) disable iff (!primed)
    (primed && rst) |=> (dout == INIT));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst || !primed)
    (primed && !en) |=> $stable(dout));

  generate
    if (MODE == tdpram_pkg::RDW_OLD) begin : g_old
      assert_old_shown_R4: assert property (@(posedge clk) disable iff (rst || !primed)
        (primed && en && (|we)) |=> (lat == $past(old_word)));
    end else if (MODE == tdpram_pkg::RDW_NEW) begin : g_new
      assert_new_shown_R5: assert property (@(posedge clk) disable iff (rst || !primed)
        (primed && en && (&we)) |=> (lat == $past(din)));
    end else begin : g_keep
      assert_keep_out_R6: assert property (@(posedge clk) disable iff (rst || !primed)
        (primed && en && (|we)) |=> $stable(lat));
    end
    if (OUT_REG) begin : g_reg
      assert_extra_stage_R9: assert property (@(posedge clk) disable iff (rst || !primed)
        (primed && en) |=> (dout == $past(lat)));
    end
  endgenerate
endmodule

bind tdpram tdpram_chk #(.LANES(LANES), .MODE(MODE_A), .OUT_REG(OUT_REG_A), .INIT(INIT_A)) u_chk_a (
  .clk(clk_a), .en(en_a), .rst(rst_a), .we(we_a), .din(din_a),
  .old_word(old_a), .lat(lat_a), .dout(dout_a)
);

bind tdpram tdpram_chk #(.LANES(LANES), .MODE(MODE_B), .OUT_REG(OUT_REG_B), .INIT(INIT_B)) u_chk_b (
  .clk(clk_b), .en(en_b), .rst(rst_b), .we(we_b), .din(din_b),
  .old_word(old_b), .lat(lat_b), .dout(dout_b)
);

// File: tb/tdpram_tb.sv
module tdpram_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [35:0] FILL   = {9'h012, 9'h034, 9'h056, 9'h078};
  localparam logic [35:0] INIT_A = 36'h5_A5A5_A5A5;
  localparam logic [35:0] INIT_B = 36'hC_3C3C_3C3C;
  localparam logic [35:0] INIT_2 = 36'h9_6969_6969;
  localparam logic [35:0] W1 = {9'h1A1, 9'h1B2, 9'h1C3, 9'h1D4};
  localparam logic [35:0] V4 = {9'h1A1, 9'h1B2, 9'h1C3, 9'h0DD};
  localparam logic [35:0] V6 = {9'h111, 9'h1B2, 9'h133, 9'h0DD};
  localparam logic [35:0] V7 = {9'h111, 9'h1B2, 9'h133, 9'h0EE};
  localparam logic [35:0] V8 = {9'h0AB, 9'h1B2, 9'h133, 9'h0EE};
  localparam logic [35:0] TOP = {9'h1FF, 9'h000, 9'h1FF, 9'h000};

  typedef struct packed {
    logic [3:0]  we;
    logic [8:0]  addr;
    logic [35:0] wd;
    logic [35:0] exp;
  } vec_t;

  // Port A of u_dut shows old data during a write (R4); no output register (R2).
  localparam vec_t VEC [10] = '{
    '{4'h0, 9'd5,   36'h0, FILL},                                       // R10
    '{4'hF, 9'd5,   W1,    FILL},                                       // R4
    '{4'h0, 9'd5,   36'h0, W1},                                         // R2
    '{4'h1, 9'd5,   {9'h0AA, 9'h0BB, 9'h0CC, 9'h0DD}, W1},              // R4
    '{4'h0, 9'd5,   36'h0, V4},                                         // R3
    '{4'hA, 9'd5,   {9'h111, 9'h122, 9'h133, 9'h144}, V4},              // R4
    '{4'h0, 9'd5,   36'h0, V6},                                         // R3
    '{4'hF, 9'd511, TOP,   FILL},                                       // R10
    '{4'h0, 9'd511, 36'h0, TOP},                                        // R2
    '{4'h0, 9'd5,   36'h0, V6}                                          // R3
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        en_a = 0, rst_a = 1, en_b = 0, rst_b = 1, en_2 = 0, rst_2 = 1;
  logic [3:0]  we_a = 0, we_b = 0, we_2 = 0;
  logic [8:0]  addr_a = 0, addr_b = 0, addr_2 = 0;
  logic [35:0] din_a = 0, din_b = 0, din_2 = 0;
  logic [35:0] dout_a, dout_b, dout_2, dout_2b;

  int checks = 0;
  int failures = 0;

  tdpram #(.MODE_A(tdpram_pkg::RDW_OLD), .MODE_B(tdpram_pkg::RDW_KEEP),
           .OUT_REG_A(1'b0), .OUT_REG_B(1'b1),
           .INIT_A(INIT_A), .INIT_B(INIT_B), .MEM_FILL(FILL)) u_dut (
    .clk_a(clk), .en_a(en_a), .rst_a(rst_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk), .en_b(en_b), .rst_b(rst_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
  );

  tdpram #(.MODE_A(tdpram_pkg::RDW_NEW), .INIT_A(INIT_2), .INIT_B(INIT_2), .MEM_FILL(FILL)) u_dut2 (
    .clk_a(clk), .en_a(en_2), .rst_a(rst_2), .we_a(we_2), .addr_a(addr_2), .din_a(din_2), .dout_a(dout_2),
    .clk_b(clk), .en_b(1'b0), .rst_b(rst_2), .we_b(4'h0), .addr_b(9'd0), .din_b(36'h0), .dout_b(dout_2b)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_a = 0; rst_b = 0; rst_2 = 0;
    check("R1 reset A", dout_a, INIT_A);
    check("R1 reset B", dout_b, INIT_B);
    check("R1 reset dut2", dout_2, INIT_2);

    for (int i = 0; i < 10; i++) begin
      en_a = 1; we_a = VEC[i].we; addr_a = VEC[i].addr; din_a = VEC[i].wd;
      tick();
      check($sformatf("vector %0d (R2/R3/R4/R10)", i), dout_a, VEC[i].exp);
    end

    // R7: disabled port neither writes nor updates
    en_a = 0; we_a = 4'hF; addr_a = 9'd5; din_a = '1;
    tick();
    check("R7 hold output", dout_a, V6);
    en_a = 1; we_a = 0;
    tick();
    check("R7 no write", dout_a, V6);
    en_a = 0;

    // R9 latency and R8 cross-port read on B
    en_b = 1; we_b = 0; addr_b = 9'd5;
    tick();
    check("R9 first edge", dout_b, INIT_B);
    tick();
    check("R8 B reads A data", dout_b, V6);

    // R6: B writes lane 0, output keeps
    we_b = 4'h1; din_b = {27'h0, 9'h0EE};
    tick();
    en_b = 0; we_b = 0;
    tick();
    check("R6 keep output", dout_b, V6);

    en_a = 1; we_a = 0; addr_a = 9'd5;
    tick();
    check("R8 A reads B lane", dout_a, V7);
    we_a = 4'h8; din_a = {9'h0AB, 27'h0};
    tick();
    check("R4 old on partial write", dout_a, V7);
    en_a = 0; we_a = 0;

    en_b = 1; addr_b = 9'd5;
    tick(); tick();
    check("R8 later writer wins", dout_b, V8);
    addr_b = 9'd511;
    tick();
    check("R9 one edge old", dout_b, V8);
    tick();
    check("R9 two edges new", dout_b, TOP);
    en_b = 0;

    // R1 mid-run in both output styles
    rst_a = 1; en_a = 1; addr_a = 9'd5;
    tick();
    rst_a = 0; en_a = 0;
    check("R1 latch reset", dout_a, INIT_A);
    tick();
    check("R1 stays idle", dout_a, INIT_A);
    rst_b = 1;
    tick();
    rst_b = 0;
    check("R1 register reset", dout_b, INIT_B);

    // R5 on dut2 port A
    en_2 = 1; addr_2 = 9'd8; we_2 = 0;
    tick();
    check("R10 dut2 fill", dout_2, FILL);
    addr_2 = 9'd7; we_2 = 4'hF; din_2 = W1;
    tick();
    check("R5 full write shown", dout_2, W1);
    we_2 = 4'h1; din_2 = {27'h0, 9'h0DD};
    tick();
    check("R5 partial write shown", dout_2, V4);
    we_2 = 0;
    tick();
    check("R3 dut2 stored", dout_2, V4);
    en_2 = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule